// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Watermarks

This block keeps the refresh account of one DRAM rank. An interval timer adds one owed refresh each time the programmed average refresh period elapses. Each refresh the command side accepts pays one back. While anything is owed, the block raises a request. The request carries a two-bit urgency that climbs as the debt passes two programmable thresholds. The command sequencer can therefore postpone refreshes while traffic is heavy and must serve them once urgency is high.

Two further sources can raise a request with no debt accrued. The first is an idle rank: once the rank has stayed idle for a programmed run of cycles, an early, opportunistic refresh is offered. The second is a separate ceiling on the time since the last refresh, which forces the highest urgency. After an accepted refresh, a busy window covers the refresh execution time. During that window no activate and no further refresh may be issued. A two-bit control can halve the refresh period, either always, never, or whenever the temperature input reports a warm device.

Top module: `refresh_sched`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `req`, `prio` and `busy` are all 0.
- R2: Counting from reset release, the owed count rises by one at the end of every P cycles. P is `cfg_interval` in normal mode, `cfg_interval` shifted right by one in double-rate mode, and 1 if that value is 0. A nonzero owed count raises `req`.
- R3: A grant is accepted when `grant` and `req` are both high at a clock edge. Each accepted grant lowers the owed count by one. `req` drops to 0 when the owed count is 0, no opportunistic condition holds and the gap limit has not expired.
- R4: The owed count saturates at 15 when it would rise and at 0 when it would fall. A grant accepted with a count of 0 leaves it at 0.
- R5: `prio` is encoded as follows. 00 means no request. 11 means the owed count is at least `cfg_panic_wm` or the gap limit has expired. 10 means the owed count is at least `cfg_hp_wm`. 01 covers any other request, whether from a small debt or from the opportunistic condition.
- R6: When `cfg_idle_lim` = L is nonzero, `req` rises after `rank_idle` has been high at L consecutive clock edges. Any edge with `rank_idle` low restarts the run. L = 0 disables opportunistic requests.
- R7: An accepted grant makes `busy` high for exactly `cfg_rfc` cycles, starting the cycle after the grant. `req` is 0 while `busy` is high.
- R8: A grant while `busy` is high, or while `req` is low, is ignored. It changes neither the owed count nor the busy window.
- R9: The double-rate control `cfg_dbl_mode` works as follows. 01 always halves the period. 10 never halves it. 00 halves it only while `temp_warm` is 1. 11 behaves as 00.
- R10: When `cfg_maxgap` = G is nonzero, `req` rises with `prio` 11 once G*1024 cycles have passed since reset or since the last accepted grant, whatever the owed count. G = 0 disables this limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_interval | input | 16 | Average refresh period in cycles |
| cfg_rfc | input | 9 | Refresh execution time in cycles |
| cfg_idle_lim | input | 8 | Idle run that triggers an opportunistic request (0 = off) |
| cfg_hp_wm | input | 4 | Owed count for high urgency |
| cfg_panic_wm | input | 4 | Owed count for panic urgency |
| cfg_dbl_mode | input | 2 | Double-rate control |
| cfg_maxgap | input | 7 | Maximum no-refresh time in 1024-cycle units (0 = off) |
| rank_idle | input | 1 | Rank has no traffic this cycle |
| temp_warm | input | 1 | DRAM is warm or hot |
| grant | input | 1 | Refresh issued this cycle |
| req | output | 1 | Refresh request |
| prio | output | 2 | Request urgency |
| busy | output | 1 | Refresh in progress; no activate or refresh allowed |

## Verification
The owed count cannot be seen directly, so any error in it must appear at the urgency output. A count that is off by one moves the 01/10/11 transitions by one interval for each watermark pair swept. A count that wraps instead of saturating shows as a request that persists or vanishes at the wrong grant when a full debt is paid back. A wrong interval or double-rate choice moves the first request edge by half a period, and this is visible within one interval of reset. A fault in the busy counter, the idle counter or the gap counter shows in the first cycle that `busy` or `req` should toggle. A grant that is wrongly accepted during busy removes a refresh that the request then fails to show once the window closes.

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int IVL_W     = 16,
  parameter int RFC_W     = 9,
  parameter int IDLE_W    = 8,
  parameter int OWED_W    = 4,
  parameter int GAP_W     = 7,
  parameter int GAP_SHIFT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IVL_W-1:0]  cfg_interval,
  input  logic [RFC_W-1:0]  cfg_rfc,
  input  logic [IDLE_W-1:0] cfg_idle_lim,
  input  logic [OWED_W-1:0] cfg_hp_wm,
  input  logic [OWED_W-1:0] cfg_panic_wm,
  input  logic [1:0]        cfg_dbl_mode,
  input  logic [GAP_W-1:0]  cfg_maxgap,
  input  logic              rank_idle,
  input  logic              temp_warm,
  input  logic              grant,
  output logic              req,
  output logic [1:0]        prio,
  output logic              busy
);
  localparam int GCNT_W = GAP_W + GAP_SHIFT;
  localparam logic [IVL_W-1:0]  IV_ONE   = 1;
  localparam logic [OWED_W-1:0] OW_ONE   = 1;
  localparam logic [OWED_W-1:0] OW_MAX   = '1;
  localparam logic [RFC_W-1:0]  RF_ONE   = 1;
  localparam logic [IDLE_W-1:0] ID_ONE   = 1;
  localparam logic [IDLE_W-1:0] ID_MAX   = '1;
  localparam logic [GCNT_W-1:0] GC_ONE   = 1;
  localparam logic [GCNT_W-1:0] GC_MAX   = '1;

  logic [IVL_W-1:0]  tmr;
  logic [OWED_W-1:0] owed;
  logic [RFC_W-1:0]  busy_cnt;
  logic [IDLE_W-1:0] idle_cnt;
  logic [GCNT_W-1:0] gap_cnt;
  logic              dbl;

  always_comb begin
    case (cfg_dbl_mode)
      2'b01:   dbl = 1'b1;
      2'b10:   dbl = 1'b0;
      default: dbl = temp_warm;
    endcase
  end

  wire [IVL_W-1:0]  per_raw = dbl ? (cfg_interval >> 1) : cfg_interval;
  wire [IVL_W-1:0]  per     = (per_raw == '0) ? IV_ONE : per_raw;
  wire              tick    = (tmr >= per - IV_ONE);
  wire              accept  = grant & req;
  wire              opp     = (cfg_idle_lim != '0) && (idle_cnt >= cfg_idle_lim);
  wire [GCNT_W-1:0] gap_lim = {cfg_maxgap, {GAP_SHIFT{1'b0}}};
  wire              gap_exp = (cfg_maxgap != '0) && (gap_cnt >= gap_lim);

  assign busy = (busy_cnt != '0);
  assign req  = !busy && ((owed != '0) || opp || gap_exp);

  always_comb begin
    if (!req)                                prio = 2'b00;
    else if (gap_exp || owed >= cfg_panic_wm) prio = 2'b11;
    else if (owed >= cfg_hp_wm)              prio = 2'b10;
    else                                     prio = 2'b01;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tmr <= '0;
    else        tmr <= tick ? '0 : tmr + IV_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owed <= '0;
    else begin
      case ({tick, accept})
        2'b10:   if (owed != OW_MAX) owed <= owed + OW_ONE;
        2'b01:   if (owed != '0)     owed <= owed - OW_ONE;
        default: owed <= owed;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              busy_cnt <= '0;
    else if (accept)         busy_cnt <= cfg_rfc;
    else if (busy_cnt != '0) busy_cnt <= busy_cnt - RF_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !rank_idle) idle_cnt <= '0;
    else if (idle_cnt != ID_MAX) idle_cnt <= idle_cnt + ID_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || accept)     gap_cnt <= '0;
    else if (gap_cnt != GC_MAX) gap_cnt <= gap_cnt + GC_ONE;
  end
endmodule

module refresh_sched_chk #(
  parameter int OWED_W = 4,
  parameter int IDLE_W = 8,
  parameter int GCNT_W = 17,
  parameter int RFC_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              grant,
  input logic              req,
  input logic              busy,
  input logic [1:0]        prio,
  input logic              rank_idle,
  input logic [OWED_W-1:0] owed,
  input logic [OWED_W-1:0] cfg_panic_wm,
  input logic [RFC_W-1:0]  cfg_rfc,
  input logic [IDLE_W-1:0] idle_cnt,
  input logic [GCNT_W-1:0] gap_cnt
);
  localparam logic [OWED_W-1:0] ONE = 1;
  localparam logic [OWED_W-1:0] TOP = '1;

  a_r2_owed_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (owed == $past(owed)) || (owed == $past(owed) + ONE) || ($past(owed) == owed + ONE));

  a_r4_hold_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (owed == TOP && !(grant && req)) |=> owed == TOP);

  a_r5_panic_level: assert property (@(posedge clk) disable iff (!rst_n)
    (req && owed >= cfg_panic_wm) |-> prio == 2'b11);

  a_r6_idle_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !rank_idle |=> idle_cnt == '0);

  a_r7_busy_follows_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && req && cfg_rfc != '0) |=> busy);

  a_r8_no_pay_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> owed >= $past(owed));

  a_r10_gap_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && req) |=> gap_cnt == '0);
endmodule

bind refresh_sched refresh_sched_chk #(
  .OWED_W(OWED_W), .IDLE_W(IDLE_W), .GCNT_W(GCNT_W), .RFC_W(RFC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .grant(grant), .req(req), .busy(busy), .prio(prio),
  .rank_idle(rank_idle), .owed(owed), .cfg_panic_wm(cfg_panic_wm), .cfg_rfc(cfg_rfc),
  .idle_cnt(idle_cnt), .gap_cnt(gap_cnt)
);

// File: tb/refresh_sched_test.sv
module refresh_sched_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_interval = 16'd10;
  logic [8:0]  cfg_rfc = 9'd5;
  logic [7:0]  cfg_idle_lim = 8'd0;
  logic [3:0]  cfg_hp_wm = 4'd3;
  logic [3:0]  cfg_panic_wm = 4'd4;
  logic [1:0]  cfg_dbl_mode = 2'b10;
  logic [6:0]  cfg_maxgap = 7'd0;
  logic        rank_idle = 1'b0;
  logic        temp_warm = 1'b0;
  logic        grant = 1'b0;
  logic        req;
  logic [1:0]  prio;
  logic        busy;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refresh_sched uut (
    .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval), .cfg_rfc(cfg_rfc),
    .cfg_idle_lim(cfg_idle_lim), .cfg_hp_wm(cfg_hp_wm), .cfg_panic_wm(cfg_panic_wm),
    .cfg_dbl_mode(cfg_dbl_mode), .cfg_maxgap(cfg_maxgap), .rank_idle(rank_idle),
    .temp_warm(temp_warm), .grant(grant), .req(req), .prio(prio), .busy(busy)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; grant = 1'b0; rank_idle = 1'b0;
    step(2);
    rst_n = 1'b1;
  endtask

  function automatic int exp_prio(int owed, int hp, int pn);
    if (owed == 0) return 0;
    if (owed >= pn) return 3;
    if (owed >= hp) return 2;
    return 1;
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    rst_n = 1'b0;
    step(2);
    chk("R1 req in reset", req, 0);
    chk("R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    chk("R1 prio after release", prio, 0);
    chk("R1 req after release", req, 0);

    // R2 R5: watermark sweep, interval 4
    for (int hp = 1; hp <= 4; hp++) begin
      for (int pn = hp; pn <= 5; pn++) begin
        cfg_interval = 16'd4; cfg_hp_wm = 4'(hp); cfg_panic_wm = 4'(pn);
        do_reset();
        step(3);
        chk("R2 no debt before first interval", req, 0);
        step(1);
        for (int k = 1; k <= 6; k++) begin
          chk("R5 prio vs owed", prio, exp_prio(k, hp, pn));
          if (k < 6) step(4);
        end
      end
    end

    // R9: double-rate modes
    for (int m = 0; m < 4; m++) begin
      for (int t = 0; t < 2; t++) begin
        int p;
        cfg_interval = 16'd10; cfg_dbl_mode = 2'(m); temp_warm = 1'(t);
        p = (m == 1 || ((m == 0 || m == 3) && t == 1)) ? 5 : 10;
        do_reset();
        step(p - 1);
        chk("R9 no request before period", req, 0);
        step(1);
        chk("R9 request at period", req, 1);
      end
    end
    cfg_dbl_mode = 2'b10; temp_warm = 1'b0;

    // R3 R7 R8: grant handling and busy window
    cfg_interval = 16'd10; cfg_hp_wm = 4'd3; cfg_panic_wm = 4'd4; cfg_rfc = 9'd5;
    do_reset();
    grant = 1'b1; step(1); grant = 1'b0;
    chk("R8 grant without req gives no busy", busy, 0);
    step(19);
    cfg_interval = 16'd60000;
    chk("R2 two owed gives low urgency", prio, 1);
    grant = 1'b1; step(1);
    chk("R7 busy after grant", busy, 1);
    chk("R7 req low while busy", req, 0);
    step(4);
    chk("R7 busy through window", busy, 1);
    grant = 1'b0; step(1);
    chk("R7 busy ends after rfc", busy, 0);
    chk("R8 grant in busy ignored", req, 1);
    grant = 1'b1; step(1); grant = 1'b0; step(5);
    chk("R3 req drops at zero debt", req, 0);
    chk("R3 prio none at zero debt", prio, 0);

    // R4: saturation at top, then payback
    cfg_interval = 16'd10;
    do_reset();
    step(200);
    cfg_interval = 16'd60000;
    chk("R4 saturated debt at panic", prio, 3);
    for (int i = 1; i <= 15; i++) begin
      grant = 1'b1; step(1); grant = 1'b0; step(5);
      chk("R4 req after payback", req, (15 - i) != 0 ? 1 : 0);
      chk("R4 prio after payback", prio, exp_prio(15 - i, 3, 4));
    end

    // R6: opportunistic sweep
    for (int l = 1; l <= 5; l++) begin
      cfg_idle_lim = 8'(l);
      do_reset();
      rank_idle = 1'b1;
      if (l > 1) begin
        step(l - 1);
        chk("R6 no req before idle run", req, 0);
      end
      step(1);
      chk("R6 req after idle run", req, 1);
      chk("R6 opportunistic prio", prio, 1);
      rank_idle = 1'b0; step(1);
      chk("R6 non-idle cycle drops req", req, 0);
      rank_idle = 1'b1;
      if (l > 1) begin
        step(l - 1);
        chk("R6 run restarted", req, 0);
      end
      step(1);
      chk("R6 req after restarted run", req, 1);
    end
    grant = 1'b1; step(1); grant = 1'b0;
    chk("R7 opportunistic grant busy", busy, 1);
    step(5);
    chk("R6 idle still counts after busy", req, 1);
    rank_idle = 1'b0; step(1);
    chk("R4 debt stays zero after early refresh", req, 0);
    cfg_idle_lim = 8'd0;
    do_reset();
    rank_idle = 1'b1; step(20);
    chk("R6 zero limit disables", req, 0);
    rank_idle = 1'b0;

    // R10: maximum no-refresh gap
    cfg_maxgap = 7'd1;
    do_reset();
    step(1023);
    chk("R10 no req before gap", req, 0);
    step(1);
    chk("R10 req at gap", req, 1);
    chk("R10 panic at gap", prio, 3);
    grant = 1'b1; step(1); grant = 1'b0; step(5);
    chk("R10 req cleared after grant", req, 0);
    step(1018);
    chk("R10 no req before second gap", req, 0);
    step(1);
    chk("R10 req at second gap", prio, 3);

    finish_run();
  end
endmodule